// File: doc/BRIEF.md
# Timer Halt and Debug-Hold Controller

This block is the mode-control slice of a general-purpose timer. It owns a free-running prescaler, an edge-counting pulse accumulator, one input-capture register with its event flag, and one write-once control register. All of them sit behind a small register bus. A halt bit in the mode register drops a clock-enable output and stops every counter and synchronizer. A debug hold applies only while the hold-enable bit is set and the external `dbg_hold` input is high. During that hold, counting and pin sampling stop, but bus access keeps working. The hold also unlocks the protected registers, so the host can preset counters or rewrite the write-once register while debugging.

Each timer pin passes through a two-stage synchronizer, and an edge is detected by comparing the two stages. On the capture path the second stage keeps shifting during a debug hold. An edge that was already inside the synchronizer when the hold began therefore still completes its capture. On the pulse-accumulator path the whole chain holds.

Register map (3-bit address): 0 mode, 1 interrupt setup, 2 prescaler, 3 pulse count, 4 capture, 5 status, 6 write-once control, 7 unused (reads zero).

Top module: `tmr_mode_ctrl`

## Requirements
- R1: After reset, every register reads zero, `clk_en` is 1 and `cap_flag` is 0. The first read issued in the cycle reset is released returns a prescaler value of 0.
- R2: The mode register holds the halt bit at bit 0 and the hold-enable bit at bit 1. All other bits read as zero. Writing bit 2 alone has no effect on counting.
- R3: While halt is set, `clk_en` is 0 and the prescaler, the pulse accumulator and the capture path do not advance. Once halt is cleared, counting resumes from the held values.
- R4: While halt is set, the interrupt setup register (address 1) and the mode register (address 0) stay readable and writable. Writes to other addresses are ignored, and reads from them return zero.
- R5: The timer is held when hold-enable is 1 and `dbg_hold` is 1. While held, the prescaler and the pulse accumulator keep their values, and changes on both pins are ignored.
- R6: The hold ends when `dbg_hold` falls or when hold-enable is cleared. The prescaler counts again from the next clock edge.
- R7: Outside halt and hold, the prescaler increments once per clock and wraps modulo 2^PSC_W.
- R8: The pulse accumulator counts rising edges of `pacc_pin` after a two-stage synchronizer and wraps modulo 2^PACC_W.
- R9: A rising edge on `cap_pin` that is set up before clock edge k loads the capture register at edge k+1 with the prescaler value present after edge k, and sets `cap_flag`.
- R10: A capture edge that has reached the first synchronizer stage before the hold begins still loads the capture register and sets the flag during the hold.
- R11: Writing 1 to status bit 0 clears `cap_flag`. Writing 0 leaves it set. Status bit 0 reads as the flag.
- R12: The prescaler, pulse count and capture registers ignore writes outside a hold and accept writes during a hold.
- R13: The write-once register (address 6) takes only the first write made outside a hold after reset. Writes made during a hold always take effect and do not use up that single write.
- R14: `bus_rdata` updates on the clock edge that samples a read strobe and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_hold | input | 1 | Debug hold request from the host |
| cap_pin | input | 1 | Input-capture pin |
| pacc_pin | input | 1 | Pulse-accumulator pin |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| clk_en | output | 1 | Clock-enable for the timer (low while halted) |
| cap_flag | output | 1 | Capture event flag |

## Verification
The bench builds the block with 4-bit prescaler and pulse-accumulator widths on an 8-bit bus. This makes counter wrap reachable within a few dozen cycles. With that setting the bench presets the prescaler to each of its 16 values and checks the captured value arithmetically, and it counts 0 to 17 pulses so that accumulator wrap is covered. It also walks the halt and hold entry and exit paths, a capture edge that straddles the start of a hold, and the write-once lock with and without writes made during a hold.

// File: rtl/tmr_mode_pkg.sv
package tmr_mode_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MCFG  = 3'd0,
    RA_ICFG  = 3'd1,
    RA_PSC   = 3'd2,
    RA_PACC  = 3'd3,
    RA_CAPT  = 3'd4,
    RA_STAT  = 3'd5,
    RA_WONCE = 3'd6,
    RA_NONE  = 3'd7
  } reg_addr_e;

  localparam int unsigned MCFG_HALT_BIT = 0;
  localparam int unsigned MCFG_HOLD_BIT = 1;
  localparam int unsigned STAT_FLAG_BIT = 0;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic shift_en,
  input  logic pin,
  output logic rise_o
);

  logic st0_q;
  logic st1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st0_q <= 1'b0;
      st1_q <= 1'b0;
    end else begin
      if (samp_en)  st0_q <= pin;
      if (shift_en) st1_q <= st0_q;
    end
  end

  assign rise_o = shift_en & st0_q & ~st1_q;

endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              held,
  input  logic              wr_mcfg,
  input  logic              wr_icfg,
  input  logic              wr_wonce,
  input  logic [DATA_W-1:0] wdata,
  output logic              halt_q,
  output logic              hold_en_q,
  output logic [DATA_W-1:0] icfg_q,
  output logic [DATA_W-1:0] wonce_q,
  output logic              wonce_lock_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= 1'b0;
      hold_en_q <= 1'b0;
    end else if (wr_mcfg) begin
      halt_q    <= wdata[MCFG_HALT_BIT];
      hold_en_q <= wdata[MCFG_HOLD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          icfg_q <= '0;
    else if (wr_icfg) icfg_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wonce_q      <= '0;
      wonce_lock_q <= 1'b0;
    end else if (wr_wonce) begin
      if (held || !wonce_lock_q) wonce_q <= wdata;
      if (!held)                 wonce_lock_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned PACC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_psc,
  input  logic              wr_pacc,
  input  logic              wr_capt,
  input  logic              clr_flag,
  input  logic [PSC_W-1:0]  wd_psc,
  input  logic [PACC_W-1:0] wd_pacc,
  input  logic              cap_rise,
  input  logic              pacc_rise,
  output logic [PSC_W-1:0]  psc_q,
  output logic [PACC_W-1:0] pacc_q,
  output logic [PSC_W-1:0]  capt_q,
  output logic              flag_q
);

  localparam logic [PSC_W-1:0]  PSC_ONE  = PSC_W'(1);
  localparam logic [PACC_W-1:0] PACC_ONE = PACC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         psc_q <= '0;
    else if (wr_psc) psc_q <= wd_psc;
    else if (cnt_en) psc_q <= psc_q + PSC_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)            pacc_q <= '0;
    else if (wr_pacc)   pacc_q <= wd_pacc;
    else if (pacc_rise) pacc_q <= pacc_q + PACC_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)           capt_q <= '0;
    else if (cap_rise) capt_q <= psc_q;
    else if (wr_capt)  capt_q <= wd_psc;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (cap_rise) flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr_mode_ctrl.sv
module tmr_mode_ctrl
  import tmr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned PACC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_hold,
  input  logic              cap_pin,
  input  logic              pacc_pin,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_en,
  output logic              cap_flag
);

  reg_addr_e         ra;
  logic              halt_q;
  logic              hold_en_q;
  logic [DATA_W-1:0] icfg_q;
  logic [DATA_W-1:0] wonce_q;
  logic              wonce_lock_q;
  logic [PSC_W-1:0]  psc_q;
  logic [PACC_W-1:0] pacc_q;
  logic [PSC_W-1:0]  capt_q;
  logic              flag_q;
  logic              held;
  logic              cnt_en;
  logic              live_en;
  logic              acc_ok;
  logic              wr_any;
  logic              cap_rise;
  logic              pacc_rise;
  logic [DATA_W-1:0] rd_nx;

  assign ra      = reg_addr_e'(bus_addr);
  assign held    = dbg_hold & hold_en_q;
  assign live_en = ~halt_q;
  assign cnt_en  = live_en & ~held;
  assign acc_ok  = ~halt_q | (ra == RA_MCFG) | (ra == RA_ICFG);
  assign wr_any  = bus_sel & bus_wr & acc_ok;

  tmr_cfg_regs #(.DATA_W(DATA_W)) cfg_i (
    .clk          (clk),
    .rst          (rst),
    .held         (held),
    .wr_mcfg      (wr_any & (ra == RA_MCFG)),
    .wr_icfg      (wr_any & (ra == RA_ICFG)),
    .wr_wonce     (wr_any & (ra == RA_WONCE)),
    .wdata        (bus_wdata),
    .halt_q       (halt_q),
    .hold_en_q    (hold_en_q),
    .icfg_q       (icfg_q),
    .wonce_q      (wonce_q),
    .wonce_lock_q (wonce_lock_q)
  );

  // capture chain: second stage keeps draining during a hold
  tmr_edge_sync cap_sync_i (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (cnt_en),
    .shift_en (live_en),
    .pin      (cap_pin),
    .rise_o   (cap_rise)
  );

  tmr_edge_sync pacc_sync_i (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (cnt_en),
    .shift_en (cnt_en),
    .pin      (pacc_pin),
    .rise_o   (pacc_rise)
  );

  tmr_count_core #(.PSC_W(PSC_W), .PACC_W(PACC_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .wr_psc    (wr_any & held & (ra == RA_PSC)),
    .wr_pacc   (wr_any & held & (ra == RA_PACC)),
    .wr_capt   (wr_any & held & (ra == RA_CAPT)),
    .clr_flag  (wr_any & (ra == RA_STAT) & bus_wdata[STAT_FLAG_BIT]),
    .wd_psc    (bus_wdata[PSC_W-1:0]),
    .wd_pacc   (bus_wdata[PACC_W-1:0]),
    .cap_rise  (cap_rise),
    .pacc_rise (pacc_rise),
    .psc_q     (psc_q),
    .pacc_q    (pacc_q),
    .capt_q    (capt_q),
    .flag_q    (flag_q)
  );

  always_comb begin
    rd_nx = '0;
    if (acc_ok) begin
      case (ra)
        RA_MCFG: begin
          rd_nx[MCFG_HALT_BIT] = halt_q;
          rd_nx[MCFG_HOLD_BIT] = hold_en_q;
        end
        RA_ICFG:  rd_nx = icfg_q;
        RA_PSC:   rd_nx = DATA_W'(psc_q);
        RA_PACC:  rd_nx = DATA_W'(pacc_q);
        RA_CAPT:  rd_nx = DATA_W'(capt_q);
        RA_STAT:  rd_nx[STAT_FLAG_BIT] = flag_q;
        RA_WONCE: rd_nx = wonce_q;
        default:  rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel & ~bus_wr) bus_rdata <= rd_nx;
  end

  assign clk_en   = ~halt_q;
  assign cap_flag = flag_q;

endmodule

// File: rtl/tmr_mode_chk.sv
module tmr_mode_chk
  import tmr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned PACC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dbg_hold,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              halt_q,
  input logic              hold_en_q,
  input logic [PSC_W-1:0]  psc_q,
  input logic [PACC_W-1:0] pacc_q,
  input logic [DATA_W-1:0] wonce_q,
  input logic              wonce_lock_q,
  input logic              cap_rise,
  input logic              cap_flag
);

  logic hold_now;
  logic wr_now;
  assign hold_now = hold_en_q && dbg_hold;
  assign wr_now   = bus_sel && bus_wr;

  // R3
  psc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> $stable(psc_q));

  // R3
  pacc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> $stable(pacc_q));

  // R5
  psc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_now && !(wr_now && bus_addr == RA_PSC)) |=> $stable(psc_q));

  // R5
  pacc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_now && !(wr_now && bus_addr == RA_PACC)) |=> $stable(pacc_q));

  // R7
  psc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && !hold_now) |=> (psc_q == PSC_W'($past(psc_q) + 1'b1)));

  // R13
  wonce_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wonce_lock_q && !hold_now) |=> $stable(wonce_q));

  // R9
  cap_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    cap_rise |=> cap_flag);

  // R4
  halt_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && halt_q && bus_addr != RA_MCFG && bus_addr != RA_ICFG)
      |=> (bus_rdata == '0));

endmodule

bind tmr_mode_ctrl tmr_mode_chk #(
  .DATA_W(DATA_W), .PSC_W(PSC_W), .PACC_W(PACC_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .dbg_hold     (dbg_hold),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .halt_q       (halt_q),
  .hold_en_q    (hold_en_q),
  .psc_q        (psc_q),
  .pacc_q       (pacc_q),
  .wonce_q      (wonce_q),
  .wonce_lock_q (wonce_lock_q),
  .cap_rise     (cap_rise),
  .cap_flag     (cap_flag)
);

// File: tb/tmr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module tmr_mode_ctrl_tb_top;

  localparam int DW = 8;
  localparam int PW = 4;
  localparam int AW = 4;
  localparam int PMOD = 1 << PW;
  localparam int AMOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dbg_hold = 1'b0;
  logic          cap_pin = 1'b0;
  logic          pacc_pin = 1'b0;
  logic          b_sel = 1'b0;
  logic          b_wr = 1'b0;
  logic [2:0]    b_addr = '0;
  logic [DW-1:0] b_wd = '0;
  logic [DW-1:0] bus_rdata;
  logic          clk_en;
  logic          cap_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tmr_mode_ctrl #(.DATA_W(DW), .PSC_W(PW), .PACC_W(AW)) dut_i (
    .clk(clk), .rst(rst), .dbg_hold(dbg_hold), .cap_pin(cap_pin),
    .pacc_pin(pacc_pin), .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wd), .bus_rdata(bus_rdata), .clk_en(clk_en), .cap_flag(cap_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [2:0] a, input logic [DW-1:0] d);
    b_sel = 1'b1; b_wr = 1'b1; b_addr = a; b_wd = d;
    @(negedge clk);
    b_sel = 1'b0; b_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output int d);
    b_sel = 1'b1; b_wr = 1'b0; b_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
    b_sel = 1'b0;
  endtask

  task automatic pulse_pacc();
    pacc_pin = 1'b1; cyc(2);
    pacc_pin = 1'b0; cyc(2);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int v, w, e;
    cyc(3);
    rst = 1'b0;
    // R1 reset state
    brd(3'd2, v); chk("R1 psc", v, 0);
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin brd(3'(a), v); chk("R1 reg", v, 0); end
    end
    chk("R1 clk_en", int'(clk_en), 1);
    chk("R1 cap_flag", int'(cap_flag), 0);

    // R7 prescaler step and wrap
    brd(3'd2, w);
    for (int i = 0; i < 20; i++) begin
      brd(3'd2, v); chk("R7 step", v, (w + 1) % PMOD); w = v;
    end

    // R3 / R4 halt
    brd(3'd2, w);
    bwr(3'd0, 8'h01);
    chk("R3 clk_en low", int'(clk_en), 0);
    for (int i = 0; i < 3; i++) begin
      pacc_pin = 1'b1; cap_pin = 1'b1; cyc(2);
      pacc_pin = 1'b0; cap_pin = 1'b0; cyc(2);
    end
    bwr(3'd1, 8'hA5);
    brd(3'd1, v); chk("R4 icfg rw", v, 'hA5);
    bwr(3'd6, 8'h3C);
    brd(3'd6, v); chk("R4 wonce read zero", v, 0);
    brd(3'd2, v); chk("R4 psc read zero", v, 0);
    brd(3'd0, v); chk("R4 mcfg read", v, 1);
    cyc(5);
    bwr(3'd0, 8'h00);
    brd(3'd2, v); chk("R3 psc resumes", v, (w + 2) % PMOD);
    chk("R3 clk_en high", int'(clk_en), 1);
    chk("R3 no capture", int'(cap_flag), 0);
    brd(3'd3, v); chk("R3 pacc held", v, 0);
    brd(3'd6, v); chk("R4 wonce untouched", v, 0);

    // R13 write-once, first part
    bwr(3'd6, 8'h11); brd(3'd6, v); chk("R13 first write", v, 'h11);
    bwr(3'd6, 8'h22); brd(3'd6, v); chk("R13 locked", v, 'h11);
    bwr(3'd0, 8'h02);
    dbg_hold = 1'b1;
    bwr(3'd6, 8'h33); brd(3'd6, v); chk("R13 hold write", v, 'h33);
    bwr(3'd6, 8'h44); brd(3'd6, v); chk("R13 hold rewrite", v, 'h44);
    dbg_hold = 1'b0;
    bwr(3'd6, 8'h55); brd(3'd6, v); chk("R13 relocked", v, 'h44);

    // R5 hold
    dbg_hold = 1'b1;
    brd(3'd2, w); cyc(4); brd(3'd2, v); chk("R5 psc held", v, w);
    for (int i = 0; i < 3; i++) begin
      pacc_pin = 1'b1; cap_pin = 1'b1; cyc(2);
      pacc_pin = 1'b0; cap_pin = 1'b0; cyc(2);
    end
    brd(3'd3, v); chk("R5 pacc held", v, 0);
    chk("R5 cap pin ignored", int'(cap_flag), 0);
    // R6 exit by input
    dbg_hold = 1'b0;
    brd(3'd2, w); brd(3'd2, v); chk("R6 exit input", v, (w + 1) % PMOD);
    // R6 exit by enable clear
    dbg_hold = 1'b1;
    brd(3'd2, e);
    bwr(3'd0, 8'h00);
    brd(3'd2, v); chk("R6 exit enable a", v, e);
    brd(3'd2, v); chk("R6 exit enable b", v, (e + 1) % PMOD);
    // R2 reserved bit
    bwr(3'd0, 8'h04);
    brd(3'd0, v); chk("R2 reserved reads zero", v, 0);
    brd(3'd2, w); brd(3'd2, v); chk("R2 reserved no hold", v, (w + 1) % PMOD);
    bwr(3'd0, 8'h02);
    brd(3'd0, v); chk("R2 hold bit", v, 2);

    // R12 protected registers
    dbg_hold = 1'b0;
    bwr(3'd3, 8'h09); brd(3'd3, v); chk("R12 pacc ro", v, 0);
    bwr(3'd4, 8'h07); brd(3'd4, v); chk("R12 capt ro", v, 0);
    dbg_hold = 1'b1;
    bwr(3'd3, 8'h09); brd(3'd3, v); chk("R12 pacc hold wr", v, 9);
    bwr(3'd4, 8'h07); brd(3'd4, v); chk("R12 capt hold wr", v, 7);

    // R8 pulse accumulator sweep
    for (int n = 0; n < 18; n++) begin
      dbg_hold = 1'b1;
      bwr(3'd3, 8'h00);
      dbg_hold = 1'b0;
      for (int k = 0; k < n; k++) pulse_pacc();
      cyc(3);
      brd(3'd3, v); chk("R8 pulse count", v, n % AMOD);
    end

    // R9 / R11 capture sweep over every prescaler value
    for (int x = 0; x < PMOD; x++) begin
      dbg_hold = 1'b1;
      bwr(3'd2, 8'(x));
      dbg_hold = 1'b0; cap_pin = 1'b1;
      cyc(2);
      cap_pin = 1'b0;
      chk("R9 flag set", int'(cap_flag), 1);
      cyc(3);
      dbg_hold = 1'b1;
      brd(3'd4, v); chk("R9 capture value", v, (x + 1) % PMOD);
      brd(3'd5, v); chk("R11 status read", v, 1);
      if (x % 2 == 1) begin
        bwr(3'd5, 8'h00); chk("R11 zero keeps", int'(cap_flag), 1);
      end
      bwr(3'd5, 8'h01); chk("R11 clear", int'(cap_flag), 0);
    end

    // R10 edge straddling hold entry
    dbg_hold = 1'b1;
    bwr(3'd2, 8'h05);
    dbg_hold = 1'b0; cap_pin = 1'b1;
    cyc(1);
    dbg_hold = 1'b1;
    cyc(3);
    chk("R10 flag", int'(cap_flag), 1);
    brd(3'd4, v); chk("R10 capture", v, 6);
    brd(3'd2, v); chk("R10 psc held", v, 6);
    cap_pin = 1'b0;
    dbg_hold = 1'b0; cyc(4);
    bwr(3'd5, 8'h01);

    // R14 registered read data
    bwr(3'd1, 8'h5A);
    brd(3'd1, v); chk("R14 read", v, 'h5A);
    bwr(3'd1, 8'h33);
    cyc(1);
    chk("R14 holds", int'(bus_rdata), 'h5A);
    brd(3'd1, v); chk("R14 new read", v, 'h33);

    // R13 hold writes do not consume the single write
    do_reset();
    bwr(3'd0, 8'h02);
    dbg_hold = 1'b1;
    bwr(3'd6, 8'h66); brd(3'd6, v); chk("R13 hold first", v, 'h66);
    dbg_hold = 1'b0;
    bwr(3'd6, 8'h77); brd(3'd6, v); chk("R13 single write kept", v, 'h77);
    bwr(3'd6, 8'h88); brd(3'd6, v); chk("R13 lock after", v, 'h77);

    summary();
    $finish;
  end

endmodule